// File: doc/BRIEF.md
# MOESI Line State Controller

This block keeps the coherence state of every line of a small private cache, using the five states Modified, Owned, Exclusive, Shared and Invalid. It takes read and write requests from its core. It watches transactions on a snooping bus that other caches issue. It drives its own bus transactions (read miss, write miss, invalidate) and writebacks to the next level. Bus arbitration and memory sit outside the block.

The tag and data stores are kept minimal: the cache is direct mapped and holds one data word per line. Three features set the protocol apart from plain MSI. An Exclusive line can be written with no bus traffic. A dirty line that another cache reads becomes Owned, and the owner supplies the data from cache to cache instead of writing it back. A write to an Owned line first invalidates the other copies.

A bus transaction finishes in the cycle `bus_gnt` is high. In that cycle the requester samples `bus_rdata` and `bus_shared`. Snoop responses are combinational in the cycle `snp_valid` is high, and the line state changes at the following clock edge.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: snoops report no hit, and the first access to any address is a miss.
- R2: A read miss issues bus command 01 (read miss) with the core address. The line fills to Exclusive when `bus_shared` is low in the grant cycle, and to Shared when it is high. The core receives `bus_rdata`.
- R3: A write hit on an Exclusive or Modified line completes without a bus request and leaves the line Modified.
- R4: A write hit on a Shared or Owned line issues bus command 11 (invalidate). After the grant the line is Modified and holds the written word.
- R5: A write miss issues bus command 10 (write miss). The line fills to Modified holding the core's write data, and the core receives that data.
- R6: A snooped read miss (01) that hits an Exclusive line asserts `snp_hit` without `snp_supply` and turns the line Shared.
- R7: A snooped read miss that hits a Modified line supplies the line's data, turns it Owned and starts no writeback. A later snooped read of an Owned line supplies the data again and leaves it Owned.
- R8: A snooped write miss (10) or invalidate (11) that hits a valid line makes it Invalid. When the line is Modified or Owned, `snp_supply` is high with the line's data in that snoop cycle.
- R9: A miss whose victim is Modified or Owned writes the victim's address and data back first, and only then issues its bus command. A Shared or Exclusive victim is replaced with no writeback.
- R10: A core request and a snoop that hit the same set in the same cycle: the snoop is applied and the core request waits one cycle. The request then acts on the state the snoop left.
- R11: If a pending invalidate loses its line to a snooped write miss or invalidate before the grant, the request turns into a write miss (10) for the same address.
- R12: A read hit returns the line's data with no bus request. `core_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core request, held until core_done |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Core word address |
| core_wdata | input | DATA_W | Core write data |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Line data after the access |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 01 read miss, 10 write miss, 11 invalidate |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_gnt | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DATA_W | Fill data in the grant cycle |
| bus_shared | input | 1 | Another cache holds the line (grant cycle) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | output | 1 | This cache holds a valid copy |
| snp_supply | output | 1 | This cache supplies the data |
| snp_data | output | DATA_W | Supplied data |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | DATA_W | Writeback data |
| wb_ack | input | 1 | Writeback accepted |

## Verification
Two functions can fall in the same cycle: a snoop changing a line and a core access to that same line. The bench provokes this in two ways. First, it raises a core write to an Exclusive line on the very clock edge where a remote read miss is snooped. The write must then come out as a bus invalidate, not a silent upgrade. Second, it holds back the grant of a pending invalidate while a remote invalidate hits the line. The bench then expects the bus command to change to a write miss, and the core to receive its own write data once the grant is given.

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_ack
);
  localparam int IW = $clog2(SETS);
  localparam int TW = ADDR_W - IW;

  localparam logic [2:0] LS_I = 3'b000;
  localparam logic [2:0] LS_S = 3'b001;
  localparam logic [2:0] LS_E = 3'b010;
  localparam logic [2:0] LS_O = 3'b011;
  localparam logic [2:0] LS_M = 3'b100;

  localparam logic [1:0] CMD_RD  = 2'b01;
  localparam logic [1:0] CMD_WR  = 2'b10;
  localparam logic [1:0] CMD_INV = 2'b11;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_BUS, F_RESP} fsm_t;

  fsm_t              fsm;
  logic [2:0]        line_st   [SETS];
  logic [TW-1:0]     line_tag  [SETS];
  logic [DATA_W-1:0] line_data [SETS];

  logic              p_we;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;
  logic [DATA_W-1:0] rdata_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;

  wire [IW-1:0] c_idx = core_addr[IW-1:0];
  wire [TW-1:0] c_tag = core_addr[ADDR_W-1:IW];
  wire [IW-1:0] s_idx = snp_addr[IW-1:0];
  wire [TW-1:0] s_tag = snp_addr[ADDR_W-1:IW];
  wire [IW-1:0] p_idx = p_addr[IW-1:0];
  wire [TW-1:0] p_tag = p_addr[ADDR_W-1:IW];

  wire [2:0] c_st    = line_st[c_idx];
  wire       c_hit   = (c_st != LS_I) && (line_tag[c_idx] == c_tag);
  wire       c_dirty = (c_st == LS_M) || (c_st == LS_O);
  wire       c_go    = (fsm == F_IDLE) && core_req && !(snp_valid && s_idx == c_idx);

  wire [2:0] s_st = line_st[s_idx];
  assign snp_hit    = snp_valid && (s_st != LS_I) && (line_tag[s_idx] == s_tag);
  assign snp_supply = snp_hit && ((s_st == LS_M) || (s_st == LS_O));
  assign snp_data   = line_data[s_idx];

  wire p_upgrade = p_we && (line_tag[p_idx] == p_tag) &&
                   ((line_st[p_idx] == LS_S) || (line_st[p_idx] == LS_O));

  assign bus_req    = (fsm == F_BUS);
  assign bus_addr   = p_addr;
  assign bus_cmd    = !p_we ? CMD_RD : (p_upgrade ? CMD_INV : CMD_WR);
  assign wb_req     = (fsm == F_WB);
  assign wb_addr    = wb_addr_q;
  assign wb_data    = wb_data_q;
  assign core_done  = (fsm == F_RESP);
  assign core_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= F_IDLE;
      p_we      <= 1'b0;
      p_addr    <= '0;
      p_wdata   <= '0;
      rdata_q   <= '0;
      wb_addr_q <= '0;
      wb_data_q <= '0;
      for (int i = 0; i < SETS; i++) begin
        line_st[i]   <= LS_I;
        line_tag[i]  <= '0;
        line_data[i] <= '0;
      end
    end else begin
      if (snp_hit) begin
        if (snp_cmd == CMD_RD) begin
          if (s_st == LS_E) line_st[s_idx] <= LS_S;
          if (s_st == LS_M) line_st[s_idx] <= LS_O;
        end else begin
          line_st[s_idx] <= LS_I;
        end
      end
      case (fsm)
        F_IDLE: if (c_go) begin
          p_we    <= core_we;
          p_addr  <= core_addr;
          p_wdata <= core_wdata;
          if (c_hit && !core_we) begin
            rdata_q <= line_data[c_idx];
            fsm     <= F_RESP;
          end else if (c_hit && (c_st == LS_M || c_st == LS_E)) begin
            line_data[c_idx] <= core_wdata;
            line_st[c_idx]   <= LS_M;
            rdata_q          <= core_wdata;
            fsm              <= F_RESP;
          end else if (!c_hit && c_dirty) begin
            wb_addr_q <= {line_tag[c_idx], c_idx};
            wb_data_q <= line_data[c_idx];
            fsm       <= F_WB;
          end else begin
            fsm <= F_BUS;
          end
        end
        F_WB: if (wb_ack) begin
          line_st[p_idx] <= LS_I;
          fsm            <= F_BUS;
        end
        F_BUS: if (bus_gnt) begin
          line_tag[p_idx]  <= p_tag;
          line_data[p_idx] <= p_we ? p_wdata : bus_rdata;
          rdata_q          <= p_we ? p_wdata : bus_rdata;
          line_st[p_idx]   <= p_we ? LS_M : (bus_shared ? LS_S : LS_E);
          fsm              <= F_RESP;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  // R9
  wb_before_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !bus_req);

  // R9
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_data)));

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)));

  // R8
  supply_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_hit);

  // R8
  snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_cmd != CMD_RD && !bus_gnt) |=> (line_st[$past(s_idx)] == LS_I));

  // R7
  owned_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_supply && snp_cmd == CMD_RD && !wb_req && !core_req) |=> !wb_req);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);
endmodule

// File: tb/sim_moesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_moesi_line_ctrl;
  logic clk = 0, rst_n = 0;
  logic core_req = 0, core_we = 0;
  logic [7:0] core_addr = 0;
  logic [15:0] core_wdata = 0;
  logic core_done;
  logic [15:0] core_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr;
  logic bus_gnt = 0;
  logic [15:0] bus_rdata = 0;
  logic bus_shared = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0;
  logic snp_hit, snp_supply;
  logic [15:0] snp_data;
  logic wb_req;
  logic [7:0] wb_addr;
  logic [15:0] wb_data;
  logic wb_ack = 0;

  int checks = 0, errors = 0;
  int bus_cnt = 0, wb_cnt = 0;
  logic [1:0] last_cmd;
  logic [7:0] last_addr, last_wb_addr;
  logic [15:0] last_wb_data;
  logic hold_gnt = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  moesi_line_ctrl u0 (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // bus and writeback responder
  initial forever begin
    @(negedge clk);
    if (bus_gnt) bus_gnt = 0;
    else if (bus_req && !hold_gnt) begin
      bus_gnt = 1; bus_cnt++; last_cmd = bus_cmd; last_addr = bus_addr;
    end
    if (wb_ack) wb_ack = 0;
    else if (wb_req) begin
      wb_ack = 1; wb_cnt++; last_wb_addr = wb_addr; last_wb_data = wb_data;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (core_done) begin
      if (exp_q.size() == 0) chk("R12 unexpected done", 1, 0);
      else chk(tag_q.pop_front(), core_rdata, exp_q.pop_front());
    end
  end

  task automatic core_op(input logic we, input logic [7:0] a, input logic [15:0] wd,
                         input logic [15:0] exp, input string r);
    exp_q.push_back(exp); tag_q.push_back(r);
    @(negedge clk);
    core_req = 1; core_we = we; core_addr = a; core_wdata = wd;
    do @(negedge clk); while (!core_done);
    core_req = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic eh,
                       input logic es, input logic [15:0] ed, input string r);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
    chk(r, snp_hit, eh);
    chk(r, snp_supply, es);
    if (es) chk(r, snp_data, ed);
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b0, w0;
    logic op_fin;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done", core_done, 0);
    chk("R1 bus", bus_req, 0);
    chk("R1 wb", wb_req, 0);
    snoop(2'b01, 8'h10, 0, 0, 0, "R1 snoop");

    // R2 exclusive fill
    bus_shared = 0; bus_rdata = 16'h1111;
    core_op(0, 8'h10, 0, 16'h1111, "R2 fill data");
    chk("R2 cmd", last_cmd, 2'b01); chk("R2 addr", last_addr, 8'h10);
    // R12 read hit
    b0 = bus_cnt;
    core_op(0, 8'h10, 0, 16'h1111, "R12 hit data");
    chk("R12 no bus", bus_cnt, b0);
    // R3 silent upgrade
    core_op(1, 8'h10, 16'h2222, 16'h2222, "R3 data");
    chk("R3 no bus", bus_cnt, b0);
    // R7 modified to owned
    w0 = wb_cnt;
    snoop(2'b01, 8'h10, 1, 1, 16'h2222, "R7 supply M");
    snoop(2'b01, 8'h10, 1, 1, 16'h2222, "R7 supply O");
    chk("R7 no wb", wb_cnt, w0);
    // R4 owned upgrade
    core_op(1, 8'h10, 16'h3333, 16'h3333, "R4 data");
    chk("R4 cmd O", last_cmd, 2'b11); chk("R4 count", bus_cnt, b0 + 1);
    // R8 write miss on modified
    snoop(2'b10, 8'h10, 1, 1, 16'h3333, "R8 supply");
    snoop(2'b01, 8'h10, 0, 0, 0, "R8 gone");

    // R2 shared fill, then R4 upgrade on Shared
    bus_shared = 1; bus_rdata = 16'h4444;
    core_op(0, 8'h05, 0, 16'h4444, "R2 shared data");
    bus_shared = 0;
    core_op(1, 8'h05, 16'h5555, 16'h5555, "R4 S data");
    chk("R4 cmd S", last_cmd, 2'b11);

    // R6 exclusive to shared on remote read
    bus_rdata = 16'h6666;
    core_op(0, 8'h06, 0, 16'h6666, "R6 fill");
    snoop(2'b01, 8'h06, 1, 0, 0, "R6 snoop");
    core_op(1, 8'h06, 16'h7777, 16'h7777, "R6 write");
    chk("R6 now shared", last_cmd, 2'b11);

    // R8 invalidate on shared
    bus_shared = 1; bus_rdata = 16'h8888;
    core_op(0, 8'h07, 0, 16'h8888, "R8 fill");
    bus_shared = 0;
    snoop(2'b11, 8'h07, 1, 0, 0, "R8 inval");
    snoop(2'b01, 8'h07, 0, 0, 0, "R8 inval gone");

    // R9 evict modified
    w0 = wb_cnt; bus_rdata = 16'h9999;
    core_op(0, 8'h09, 0, 16'h9999, "R9 fill");
    chk("R9 wb count", wb_cnt, w0 + 1);
    chk("R9 wb addr", last_wb_addr, 8'h05); chk("R9 wb data", last_wb_data, 16'h5555);
    chk("R9 cmd", last_cmd, 2'b01); chk("R9 cmd addr", last_addr, 8'h09);
    // R9 evict exclusive silently
    w0 = wb_cnt; bus_rdata = 16'h0D0D;
    core_op(0, 8'h0D, 0, 16'h0D0D, "R9 clean fill");
    chk("R9 clean no wb", wb_cnt, w0);

    // R5 write miss
    bus_rdata = 16'h1234;
    core_op(1, 8'h20, 16'hAAAA, 16'hAAAA, "R5 data");
    chk("R5 cmd", last_cmd, 2'b10); chk("R5 addr", last_addr, 8'h20);
    snoop(2'b01, 8'h20, 1, 1, 16'hAAAA, "R5 held M");
    // R9 evict owned
    w0 = wb_cnt; bus_rdata = 16'h0101;
    core_op(0, 8'h10, 0, 16'h0101, "R9 O fill");
    chk("R9 O wb", wb_cnt, w0 + 1);
    chk("R9 O wb addr", last_wb_addr, 8'h20); chk("R9 O wb data", last_wb_data, 16'hAAAA);

    // R10 same-cycle snoop and core write on an Exclusive line
    bus_rdata = 16'h0B0B;
    core_op(0, 8'h0A, 0, 16'h0B0B, "R10 fill");
    b0 = bus_cnt;
    fork
      core_op(1, 8'h0A, 16'hC0C0, 16'hC0C0, "R10 data");
      snoop(2'b01, 8'h0A, 1, 0, 0, "R10 snoop");
    join
    chk("R10 bus used", bus_cnt, b0 + 1);
    chk("R10 cmd", last_cmd, 2'b11);

    // R11 pending upgrade loses the line
    bus_shared = 1; bus_rdata = 16'h0E0E;
    core_op(0, 8'h0B, 0, 16'h0E0E, "R11 fill");
    bus_shared = 0; hold_gnt = 1; op_fin = 0;
    fork
      begin core_op(1, 8'h0B, 16'hD0D0, 16'hD0D0, "R11 data"); op_fin = 1; end
    join_none
    repeat (3) @(negedge clk);
    #1;
    chk("R11 req", bus_req, 1); chk("R11 inv first", bus_cmd, 2'b11);
    snoop(2'b11, 8'h0B, 1, 0, 0, "R11 snoop");
    #1;
    chk("R11 becomes wm", bus_cmd, 2'b10);
    hold_gnt = 0;
    wait (op_fin);
    chk("R11 granted cmd", last_cmd, 2'b10);
    chk("R11 addr", last_addr, 8'h0B);

    repeat (3) @(negedge clk);
    chk("R12 queue empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule